// File: doc/BRIEF.md
# Chaotic-Map Keystream Cipher

This block is a byte-wide stream cipher. Its keystream comes from a shift-type chaotic map: a 32-bit fractional state is multiplied by a control factor near two, and only the fractional part of the product is kept. Two 32-bit linear-feedback generators support the map. The seeding generator only works during a short start-up phase, and its job is to seed the second one. The running generator is stepped once for every byte. On each step it disturbs the map's control factor, it provides a fresh state when the map degenerates, and it whitens each map output before that output is used.

To use the block, software loads a key (the initial map state) and a seed, then pulses `start`. After a fixed number of start-up cycles the block raises `running`. From then on, every qualified plaintext byte is combined with the low byte of a new keystream word. The ciphertext and the full keystream word leave the pipeline a fixed number of cycles later. Loading the same key and seed again reproduces the same keystream, so the same block decrypts by feeding ciphertext through it.

Top module: `chaos_stream_cipher`

## Requirements
- R1: While reset is held, and right after it, `running`, `ct_valid`, `ct_byte` and `ks_tap` are all zero.
- R2: A seed of zero is replaced by the constant 32'hACE1_2B5D. Loading seed 0 gives exactly the same keystream as loading 32'hACE1_2B5D.
- R3: If `start` is sampled high while the block is idle, `running` goes high after exactly INIT_CYCLES (default 4) further clock edges. During that time the seeding generator steps once per cycle, using the Galois right-shift rule `s' = (s>>1) ^ (s[0] ? 32'h8020_0003 : 0)`. The running generator is then loaded with the seeding generator's final value. Once high, `running` stays high until the next key load.
- R4: For each accepted byte, the control factor mu (Q2.16, 18 bits, reset and load value 1.75 = 18'h1C000) is XORed in its low 16 bits with the running generator's low 16 bits. The result is clamped to [18'h18000, 18'h20000]. The next state is the product mu*x (x in Q0.32), truncated to 48 bits. Bits 47:17 of that product are kept, and bit 0 becomes bit 16 ORed with all of bits 15:0.
- R5: If that map result is all zeros or all ones, the state is instead reloaded with `{1'b0, r[30:1], 1'b1}`, where r is the running generator's current value.
- R6: If the map result is not degenerate but is below 32'h0001_0000, the constant 32'h9E37_79B9 is added to it, modulo 2^32.
- R7: The keystream word is the new state XORed with the running generator's value with its halves swapped (`{r[15:0], r[31:16]}`). The running generator then steps once.
- R8: `ct_byte` equals the plaintext byte XOR keystream bits 7:0. A byte accepted at clock edge n shows up with `ct_valid` high and its keystream on `ks_tap` after edge n+7. That is eight registers, so the output is sampled at edge n+8.
- R9: A byte is accepted only when `running` is high and `key_load` is low. Bytes offered while idle or during start-up produce no output and do not change the keystream.
- R10: `key_load` returns the block to idle, with state = key and mu = 1.75. Repeating the same key, seed and start sequence reproduces the keystream bit for bit, so feeding the ciphertext back in returns the plaintext.
- R11: Cycles where `pt_valid` is low advance neither the map nor the running generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_load | input | 1 | Load key and seed, return to idle |
| key_in | input | 32 | Initial map state (Q0.32) |
| seed_in | input | 32 | Seed for the seeding generator |
| start | input | 1 | Begin the start-up phase when idle |
| pt_valid | input | 1 | Plaintext byte qualifier |
| pt_byte | input | 8 | Plaintext byte |
| running | output | 1 | Block accepts bytes |
| ct_valid | output | 1 | Ciphertext byte qualifier |
| ct_byte | output | 8 | Ciphertext byte |
| ks_tap | output | 32 | Keystream word used for `ct_byte` (zero when not valid) |

## Verification
The map is driven with random keys and seeds and with random byte streams that have random idle gaps. This separates a correct per-byte advance from one that advances every cycle, and a correct map and whitening step from a wrong one. The directed key values 0 and 1 force the degenerate-reload branch and the low-value offset branch, which random keys almost never reach. Loading seed 0 and loading the substitute constant must produce identical keystreams, which shows the substitution is in place. Finally, ciphertext is fed back in after reloading the same key and seed, which shows that decryption and reproducibility hold end to end.

// File: rtl/chaos_pkg.sv
// Shared widths, state encoding and the pipeline stage record.
// Assumes a 32-bit map state and byte-wide data.
package chaos_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int MU_W   = 18;  // Q2.16 control factor
    localparam int MU_FRAC = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
        logic [WORD_W-1:0] ks;
    } stage_t;
endpackage

// File: rtl/cs_lfsr.sv
// Galois right-shift LFSR with zero-seed substitution.
// Assumes TAPS describes a maximal-length polynomial; ZERO_SUB is non-zero.
module cs_lfsr #(
    parameter int             W        = 32,
    parameter logic [W-1:0]   TAPS     = 32'h8020_0003,
    parameter logic [W-1:0]   ZERO_SUB = 32'hACE1_2B5D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic [W-1:0] nxt
);
    // One Galois step of the current state.
    always_comb begin
        nxt = {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
    end

    // State register: load has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ZERO_SUB;
        end else if (load) begin
            state <= (load_val == '0) ? ZERO_SUB : load_val;
        end else if (adv) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/cs_ctrl.sv
// Phase sequencer: idle, start-up (seeding generator runs), running.
// Assumes INIT_CYCLES >= 1; key_load overrides everything.
module cs_ctrl
    import chaos_pkg::*;
#(
    parameter int INIT_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   key_load,
    input  logic   start,
    output phase_t phase,
    output logic   seed_adv,
    output logic   init_done
);
    localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Step the seeding generator during start-up; flag the last start-up cycle.
    always_comb begin
        seed_adv  = (phase == PH_INIT) && !key_load;
        init_done = seed_adv && (cnt == LAST);
    end

    // Phase and start-up counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (key_load) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_INIT;
                        cnt   <= '0;
                    end
                end
                PH_INIT: begin
                    if (cnt == LAST) begin
                        phase <= PH_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= phase;
            endcase
        end
    end
endmodule

// File: rtl/cs_map_core.sv
// Chaotic map iteration with control-factor perturbation, clamping,
// jam rounding, degeneracy reload, low-value offset and output whitening.
// Assumes PERT_W <= MU_W and W even; one iteration per accepted byte.
module cs_map_core
    import chaos_pkg::*;
#(
    parameter int              W         = WORD_W,
    parameter int              PERT_W    = 16,
    parameter logic [MU_W-1:0] MU_INIT   = 18'h1C000,
    parameter logic [MU_W-1:0] MU_MIN    = 18'h18000,
    parameter logic [MU_W-1:0] MU_MAX    = 18'h20000,
    parameter logic [W-1:0]    LOW_LIMIT = 32'h0001_0000,
    parameter logic [W-1:0]    OFFSET    = 32'h9E37_79B9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    key,
    input  logic            iter,
    input  logic [W-1:0]    r,
    output logic [W-1:0]    x_q,
    output logic [MU_W-1:0] mu_q,
    output logic [W-1:0]    ks
);
    localparam int PW = W + MU_FRAC;  // product width kept
    localparam int HW = W / 2;

    logic [MU_W-1:0] mu_mix, mu_p;
    logic [PW-1:0]   prod;
    logic [W-1:0]    x_raw, x_fix, reload_val;
    logic            degen;

    // Perturb the control factor and clamp it into its legal band.
    always_comb begin
        mu_mix = mu_q ^ {{(MU_W-PERT_W){1'b0}}, r[PERT_W-1:0]};
        if (mu_mix < MU_MIN)      mu_p = MU_MIN;
        else if (mu_mix > MU_MAX) mu_p = MU_MAX;
        else                      mu_p = mu_mix;
    end

    // Fractional product with jam rounding on the dropped bits.
    always_comb begin
        prod  = {{(PW-MU_W){1'b0}}, mu_p} * {{(PW-W){1'b0}}, x_q};
        x_raw = {prod[PW-1:MU_FRAC+1], prod[MU_FRAC] | (|prod[MU_FRAC-1:0])};
    end

    // Degeneracy and low-value correction, then whitening.
    always_comb begin
        degen      = (x_raw == '0) || (x_raw == '1);
        reload_val = {1'b0, r[W-2:1], 1'b1};
        if (degen)                  x_fix = reload_val;
        else if (x_raw < LOW_LIMIT) x_fix = x_raw + OFFSET;
        else                        x_fix = x_raw;
        ks = x_fix ^ {r[HW-1:0], r[W-1:HW]};
    end

    // Map state and control-factor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            mu_q <= MU_INIT;
        end else if (load) begin
            x_q  <= key;
            mu_q <= MU_INIT;
        end else if (iter) begin
            x_q  <= x_fix;
            mu_q <= mu_p;
        end
    end
endmodule

// File: rtl/cs_pipe.sv
// Fixed-length delay line carrying valid, ciphertext and keystream word.
// Assumes DEPTH >= 1; every stage loads every cycle.
module cs_pipe
    import chaos_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t din,
    output stage_t dout
);
    stage_t regs [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                // First stage captures the freshly mixed byte.
                always_ff @(posedge clk) begin
                    if (!rst_n) regs[0] <= '0;
                    else        regs[0] <= din;
                end
            end else begin : g_body
                // Later stages shift the record one step.
                always_ff @(posedge clk) begin
                    if (!rst_n) regs[i] <= '0;
                    else        regs[i] <= regs[i-1];
                end
            end
        end
    endgenerate

    assign dout = regs[DEPTH-1];
endmodule

// File: rtl/chaos_stream_cipher.sv
// Top: byte stream cipher around a perturbed chaotic map.
// Assumes key_load dominates start and pt_valid in the same cycle.
module chaos_stream_cipher
    import chaos_pkg::*;
#(
    parameter int INIT_CYCLES = 4,
    parameter int PIPE_DEPTH  = 8,
    parameter int PERT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_load,
    input  logic [WORD_W-1:0] key_in,
    input  logic [WORD_W-1:0] seed_in,
    input  logic              start,
    input  logic              pt_valid,
    input  logic [BYTE_W-1:0] pt_byte,
    output logic              running,
    output logic              ct_valid,
    output logic [BYTE_W-1:0] ct_byte,
    output logic [WORD_W-1:0] ks_tap
);
    phase_t            phase;
    logic              seed_adv, init_done, acc;
    logic [WORD_W-1:0] seed_state, seed_nxt, run_state, run_nxt;
    logic [WORD_W-1:0] x_q, ks;
    logic [MU_W-1:0]   mu_q;
    stage_t            pin, pout;

    cs_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .start(start),
        .phase(phase), .seed_adv(seed_adv), .init_done(init_done)
    );

    cs_lfsr #(.W(WORD_W)) u_seed_gen (
        .clk(clk), .rst_n(rst_n), .load(key_load), .load_val(seed_in),
        .adv(seed_adv), .state(seed_state), .nxt(seed_nxt)
    );

    cs_lfsr #(.W(WORD_W)) u_run_gen (
        .clk(clk), .rst_n(rst_n), .load(init_done), .load_val(seed_nxt),
        .adv(acc), .state(run_state), .nxt(run_nxt)
    );

    cs_map_core #(.W(WORD_W), .PERT_W(PERT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(key_load), .key(key_in),
        .iter(acc), .r(run_state), .x_q(x_q), .mu_q(mu_q), .ks(ks)
    );

    // Acceptance and first-stage mixing of the plaintext byte.
    always_comb begin
        running = (phase == PH_RUN);
        acc     = running && pt_valid && !key_load;
        pin     = acc ? '{vld: 1'b1, dat: pt_byte ^ ks[BYTE_W-1:0], ks: ks} : '0;
    end

    cs_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .din(pin), .dout(pout)
    );

    assign ct_valid = pout.vld;
    assign ct_byte  = pout.dat;
    assign ks_tap   = pout.ks;
endmodule

// File: rtl/cs_checker.sv
// Property checker bound to the cipher top; observes ports and internal nets.
module cs_checker
    import chaos_pkg::*;
#(
    parameter logic [MU_W-1:0] MU_MIN = 18'h18000,
    parameter logic [MU_W-1:0] MU_MAX = 18'h20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_load,
    input logic              pt_valid,
    input logic              running,
    input logic              acc,
    input logic              ct_valid,
    input logic [WORD_W-1:0] x_q,
    input logic [MU_W-1:0]   mu_q,
    input logic [WORD_W-1:0] run_state,
    input logic [WORD_W-1:0] run_nxt
);
    p_mu_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mu_q >= MU_MIN) && (mu_q <= MU_MAX))
        else $error("mu outside band");

    p_state_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (x_q != '0) && (x_q != '1))
        else $error("map state degenerate after iteration");

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> $past(acc, 8))
        else $error("output without matching acceptance");

    p_stay_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running && !key_load |=> running)
        else $error("running dropped without key load");

    p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> !running)
        else $error("still running after key load");

    p_gap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running && !pt_valid && !key_load |=> $stable(run_state) && $stable(x_q))
        else $error("state moved on an idle cycle");

    p_gen_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> run_state == $past(run_nxt))
        else $error("running generator did not step");
endmodule

bind chaos_stream_cipher cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .pt_valid(pt_valid),
    .running(running), .acc(acc), .ct_valid(ct_valid), .x_q(x_q),
    .mu_q(mu_q), .run_state(run_state), .run_nxt(run_nxt)
);

// File: tb/chaos_stream_cipher_test.sv
module chaos_stream_cipher_test;
    localparam int INIT_N = 4;
    localparam logic [31:0] TAPS   = 32'h8020_0003;
    localparam logic [31:0] ZSUB   = 32'hACE1_2B5D;
    localparam logic [31:0] OFFS   = 32'h9E37_79B9;
    localparam logic [17:0] MU0    = 18'h1C000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic key_load = 0, start = 0, pt_valid = 0;
    logic [31:0] key_in = 0, seed_in = 0;
    logic [7:0]  pt_byte = 0;
    logic running, ct_valid;
    logic [7:0]  ct_byte;
    logic [31:0] ks_tap;

    chaos_stream_cipher uut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .seed_in(seed_in), .start(start), .pt_valid(pt_valid), .pt_byte(pt_byte),
        .running(running), .ct_valid(ct_valid), .ct_byte(ct_byte), .ks_tap(ks_tap)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0, fails = 0, cyc = 0, outs = 0;
    bit done = 0, rec = 0;
    string tag = "R8";
    logic [31:0] m_seed, m_run, m_x;
    logic [17:0] m_mu;
    bit m_running = 0;
    logic [7:0]  q_ct[$];
    logic [31:0] q_ks[$];
    int          q_cy[$];
    logic [7:0]  cap_ct[$];
    logic [31:0] cap_ks[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string t, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] f_step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    endfunction

    function automatic logic [31:0] f_nz(input logic [31:0] s);
        return (s == 0) ? ZSUB : s;
    endfunction

    // Reference iteration built from R4..R7.
    task automatic model_iter(input logic [7:0] pt, output logic [7:0] ct, output logic [31:0] ks);
        logic [17:0] mu;
        logic [47:0] p;
        logic [31:0] raw, x;
        mu = m_mu ^ {2'b0, m_run[15:0]};
        if (mu < 18'h18000) mu = 18'h18000;
        else if (mu > 18'h20000) mu = 18'h20000;
        p = {30'b0, mu} * {16'b0, m_x};
        raw = {p[47:17], p[16] | (|p[15:0])};
        if (raw == 32'h0 || raw == 32'hFFFF_FFFF) x = {1'b0, m_run[30:1], 1'b1};
        else if (raw < 32'h0001_0000) x = raw + OFFS;
        else x = raw;
        ks = x ^ {m_run[15:0], m_run[31:16]};
        ct = pt ^ ks[7:0];
        m_x = x; m_mu = mu; m_run = f_step(m_run);
    endtask

    // Output monitor: compares against queued expectations (R7, R8).
    always @(negedge clk) begin
        if (rst_n && !done && ct_valid) begin
            outs++;
            if (q_ct.size() == 0) begin
                chk({tag, " unexpected output"}, 0, {24'b0, ct_byte}, 32'h0);
            end else begin
                logic [7:0] e_ct; logic [31:0] e_ks; int e_cy;
                e_ct = q_ct.pop_front(); e_ks = q_ks.pop_front(); e_cy = q_cy.pop_front();
                chk({tag, " R8 ciphertext"}, ct_byte === e_ct, {24'b0, ct_byte}, {24'b0, e_ct});
                chk({tag, " R7 keystream"}, ks_tap === e_ks, ks_tap, e_ks);
                chk("R8 latency", cyc == e_cy, cyc, e_cy);
                if (rec) begin
                    cap_ct.push_back(ct_byte);
                    cap_ks.push_back(ks_tap);
                end
            end
        end
    end

    task automatic send(input bit v, input logic [7:0] b);
        logic [7:0] c; logic [31:0] k;
        @(negedge clk);
        pt_valid = v; pt_byte = b;
        if (v && m_running) begin
            model_iter(b, c, k);
            q_ct.push_back(c); q_ks.push_back(k); q_cy.push_back(cyc + 8);
        end
    endtask

    task automatic drain();
        repeat (12) send(0, 8'h00);
    endtask

    task automatic do_load(input logic [31:0] k, input logic [31:0] s);
        @(negedge clk);
        key_load = 1; key_in = k; seed_in = s; pt_valid = 0;
        @(negedge clk);
        key_load = 0;
        m_seed = f_nz(s); m_x = k; m_mu = MU0; m_running = 0;
        chk("R10 idle after load", running == 0, {31'b0, running}, 32'h0);
    endtask

    // Start-up with bytes offered during it (must be dropped, R9).
    task automatic do_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0; pt_valid = 1; pt_byte = 8'h5A;
        repeat (INIT_N - 1) @(negedge clk);
        chk("R3 not yet running", running == 0, {31'b0, running}, 32'h0);
        @(negedge clk);
        pt_valid = 0;
        chk("R3 running after start-up", running == 1, {31'b0, running}, 32'h1);
        repeat (INIT_N) m_seed = f_step(m_seed);
        m_run = f_nz(m_seed); m_running = 1;
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) send(0, 8'h00);  // gap, R11
            send(1, 8'($urandom));
        end
        drain();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  pts[$];
        logic [31:0] ks1[$];
        logic [7:0]  ct1[$];
        int o0;
        void'($urandom(32'd7311));
        repeat (3) @(negedge clk);
        chk("R1 running in reset", running == 0, {31'b0, running}, 32'h0);
        chk("R1 ct_valid in reset", ct_valid == 0, {31'b0, ct_valid}, 32'h0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 ks_tap after reset", ks_tap == 0, ks_tap, 32'h0);
        chk("R1 ct_byte after reset", ct_byte == 0, {24'b0, ct_byte}, 32'h0);

        // R9: bytes while idle produce nothing
        tag = "R9";
        o0 = outs;
        repeat (5) send(1, 8'hC3);
        drain();
        chk("R9 idle bytes dropped", outs == o0, outs, o0);

        // Main stream with recording for R10
        tag = "R4";
        do_load(32'h3C6E_F372, 32'h1234_5678);
        do_start();
        chk("R9 init bytes dropped", outs == o0, outs, o0);
        rec = 1;
        for (int i = 0; i < 150; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            pts.push_back(b);
            if ($urandom_range(0, 2) == 0) send(0, 8'h00);  // R11 gaps
            send(1, b);
        end
        drain();
        rec = 0;
        while (cap_ct.size() > 0) begin
            ct1.push_back(cap_ct.pop_front());
            ks1.push_back(cap_ks.pop_front());
        end
        chk("R8 output count", ct1.size() == 150, ct1.size(), 150);

        // R10: reload and decrypt
        tag = "R10";
        do_load(32'h3C6E_F372, 32'h1234_5678);
        do_start();
        rec = 1;
        foreach (ct1[i]) send(1, ct1[i]);
        drain();
        rec = 0;
        chk("R10 replay count", cap_ct.size() == ct1.size(), cap_ct.size(), ct1.size());
        foreach (cap_ct[i]) begin
            if (i < pts.size()) begin
                chk("R10 decrypt", cap_ct[i] == pts[i], {24'b0, cap_ct[i]}, {24'b0, pts[i]});
                chk("R10 keystream repeat", cap_ks[i] == ks1[i], cap_ks[i], ks1[i]);
            end
        end
        cap_ct.delete(); cap_ks.delete(); ks1.delete();

        // R2: zero seed equals substitute constant
        tag = "R2";
        do_load(32'h8765_4321, 32'h0);
        do_start();
        rec = 1;
        for (int i = 0; i < 20; i++) send(1, 8'(i));
        drain();
        rec = 0;
        while (cap_ks.size() > 0) begin ks1.push_back(cap_ks.pop_front()); void'(cap_ct.pop_front()); end
        do_load(32'h8765_4321, ZSUB);
        do_start();
        rec = 1;
        for (int i = 0; i < 20; i++) send(1, 8'(i));
        drain();
        rec = 0;
        foreach (cap_ks[i])
            if (i < ks1.size())
                chk("R2 zero-seed substitution", cap_ks[i] == ks1[i], cap_ks[i], ks1[i]);
        cap_ct.delete(); cap_ks.delete();

        // R5: key 0 forces degeneracy reload
        tag = "R5";
        do_load(32'h0, 32'hDEAD_BEEF);
        do_start();
        stream(12);

        // R6: key 1 forces low-value offset
        tag = "R6";
        do_load(32'h1, 32'h0BAD_F00D);
        do_start();
        stream(12);

        // R4/R7/R11: random keys and seeds
        tag = "R4";
        for (int k = 0; k < 4; k++) begin
            do_load($urandom, $urandom);
            do_start();
            stream(60);
        end

        chk("R8 all expectations consumed", q_ct.size() == 0, q_ct.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule